// File: doc/BRIEF.md
# Common Pedestal Estimator and Subtractor

This block sits after a front-end frame parser that delivers one digitized channel sample per clock, each tagged with a valid flag and a channel number. It removes a single common baseline, the pedestal, from every channel of the chip. The corrected samples leave through a fixed two-stage pipeline. Samples without the valid flag produce no output.

The pedestal comes from one of two sources, chosen by a mode input. In manual mode it is a value presented on a dedicated input. In automatic mode it is an internal estimate. A start pulse arms a measurement, and the measurement then averages one full frame of valid samples, beginning at channel zero. While it runs, a busy flag is high. The estimate then stays fixed until the next accepted start. A subtraction enable lets the raw samples pass through untouched when it is low.

Top module: `common_pedestal_sub`

## Requirements
- R1: While reset is held, and up to the first input after it, out_valid is 0, out_data is 0, ped_est is 0 and busy is 0.
- R2: A sample presented with in_valid=1 at a clock edge appears on out_data with out_valid=1 exactly two clock edges later. One sample is accepted on every clock.
- R3: When sub_en was 0 at a sample's input edge, out_data equals the input sample unchanged.
- R4: When sub_en was 1, out_data is the sample minus the applied pedestal. The result is clamped to 0 when the pedestal exceeds the sample.
- R5: With mode_manual=1, the applied pedestal is the value on manual_ped at the sample's input edge.
- R6: With mode_manual=0, the applied pedestal is the stored automatic estimate as it stood before that edge.
- R7: A start pulse taken while idle raises busy at that same edge. The measurement begins with the first valid sample on channel 0, and channel numbers before that are ignored. It then takes 128 valid samples. At the edge that takes the 128th sample, ped_est becomes their sum shifted right by 7 bits, and busy returns to 0.
- R8: Samples with in_valid=0 add nothing to the estimate and produce no output. While out_valid is 0, out_data holds its last value.
- R9: A start pulse taken while busy is 1 is ignored: the measurement in progress continues unchanged.
- R10: ped_est always shows the stored automatic estimate, whatever the mode. It changes only at the completion of a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Parsed channel sample |
| in_valid | input | 1 | Sample qualifier |
| in_chan | input | CHW | Channel number of the sample |
| start | input | 1 | Arms an automatic measurement |
| mode_manual | input | 1 | 1 selects manual_ped, 0 selects the automatic estimate |
| manual_ped | input | DW | Manually supplied pedestal |
| sub_en | input | 1 | 1 subtracts the pedestal, 0 passes data through |
| out_data | output | DW | Corrected sample |
| out_valid | output | 1 | Corrected sample qualifier |
| ped_est | output | DW | Stored automatic pedestal estimate |
| busy | output | 1 | Measurement in progress |

## Verification
A corrected sample is due two edges after its input edge. The driver therefore pushes each sample's expected value, computed from the pedestal and mode in force at that edge, into a queue. The monitor pops one entry on every falling edge where out_valid is high, which keeps the comparison aligned to that latency. Busy and ped_est follow the sampling edge by one register. They are checked on the falling edge right after the start pulse, and on the falling edge right after the 128th frame sample. The check after the 127th sample confirms that busy is still high.

// File: rtl/common_pedestal_sub.sv
module common_pedestal_sub #(
  parameter int DW  = 12,
  parameter int CHW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  in_data,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_chan,
  input  logic           start,
  input  logic           mode_manual,
  input  logic [DW-1:0]  manual_ped,
  input  logic           sub_en,
  output logic [DW-1:0]  out_data,
  output logic           out_valid,
  output logic [DW-1:0]  ped_est,
  output logic           busy
);
  localparam int NCH = 1 << CHW;
  localparam int AW  = DW + CHW;

  typedef enum logic [1:0] {IDLE, ARM, ACC} st_t;

  st_t            st;
  logic [AW-1:0]  acc;
  logic [CHW-1:0] cnt;
  logic [DW-1:0]  ped_q;

  logic [AW-1:0]  sum_nx;
  logic           first_take;
  logic           last_take;

  assign sum_nx     = acc + AW'(in_data);
  assign first_take = (st == ARM) && in_valid && (in_chan == '0);
  assign last_take  = (st == ACC) && in_valid && (cnt == CHW'(NCH - 1));
  assign busy       = (st != IDLE);
  assign ped_est    = ped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      acc   <= '0;
      cnt   <= '0;
      ped_q <= '0;
    end else begin
      case (st)
        IDLE: if (start) st <= ARM;
        ARM: if (first_take) begin
          acc <= AW'(in_data);
          cnt <= CHW'(1);
          st  <= (NCH == 1) ? IDLE : ACC;
          if (NCH == 1) ped_q <= in_data;
        end
        ACC: if (in_valid) begin
          acc <= sum_nx;
          cnt <= cnt + 1'b1;
          if (last_take) begin
            ped_q <= sum_nx[AW-1:CHW];
            st    <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic          v1, e1;
  logic [DW-1:0] d1, p1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      e1 <= 1'b0;
      d1 <= '0;
      p1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        d1 <= in_data;
        e1 <= sub_en;
        p1 <= mode_manual ? manual_ped : ped_q;
      end
    end
  end

  logic [DW-1:0] diff;
  assign diff = (d1 > p1) ? (d1 - p1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_data <= e1 ? diff : d1;
    end
  end
endmodule

// File: rtl/pedestal_sub_chk.sv
module pedestal_sub_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] in_data,
  input logic          in_valid,
  input logic          start,
  input logic          sub_en,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic [DW-1:0] ped_est,
  input logic          busy
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && !$past(sub_en, 2)) |-> (out_data == $past(in_data, 2)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid) |-> (out_data <= $past(in_data, 2)));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(start) && !$past(busy)) |-> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !out_valid) |-> $stable(out_data));

  p_est_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !$past(busy)) |-> $stable(ped_est));
endmodule

bind common_pedestal_sub pedestal_sub_chk #(.DW(DW)) u_chk (.*);

// File: tb/common_pedestal_sub_tb.sv
module common_pedestal_sub_tb;
  localparam int DW = 12;
  localparam int CHW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic [CHW-1:0] in_chan = '0;
  logic start = 1'b0;
  logic mode_manual = 1'b0;
  logic [DW-1:0] manual_ped = '0;
  logic sub_en = 1'b0;
  logic [DW-1:0] out_data;
  logic out_valid;
  logic [DW-1:0] ped_est;
  logic busy;

  always #4 clk = ~clk;

  common_pedestal_sub #(.DW(DW), .CHW(CHW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_chan(in_chan), .start(start), .mode_manual(mode_manual),
    .manual_ped(manual_ped), .sub_en(sub_en), .out_data(out_data),
    .out_valid(out_valid), .ped_est(ped_est), .busy(busy));

  int total = 0;
  int bad = 0;
  int tb_auto = 0;
  int exp_q[$];
  string tag_q[$];
  logic [DW-1:0] last_out = '0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int d, int ch, bit v, string tag);
    int ped, e;
    in_data  = DW'(d);
    in_chan  = CHW'(ch);
    in_valid = v;
    if (v) begin
      ped = mode_manual ? int'(manual_ped) : tb_auto;
      e = sub_en ? ((d > ped) ? d - ped : 0) : d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected output", 1, 0);
        else check(tag_q.pop_front(), int'(out_data), exp_q.pop_front());
        last_out = out_data;
      end else begin
        check("R8 hold", int'(out_data), int'(last_out));
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sum;
    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);
    check("R1 ped_est", int'(ped_est), 0);
    check("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after", int'(busy), 0);

    // R3 bypass
    sub_en = 0; mode_manual = 0;
    drive(5, 0, 1, "R3 bypass");
    drive(4095, 1, 1, "R3 bypass");
    drive(0, 2, 1, "R3 bypass");
    drive(1234, 3, 1, "R3 bypass");

    // R4 R5 manual subtraction with clamp
    sub_en = 1; mode_manual = 1; manual_ped = 500;
    drive(600, 0, 1, "R5 manual");
    drive(500, 1, 1, "R4 equal");
    drive(499, 2, 1, "R4 clamp");
    drive(4095, 3, 1, "R5 manual");
    manual_ped = 7;
    drive(10, 4, 1, "R5 manual change");

    // R6 auto with zero estimate
    mode_manual = 0;
    drive(77, 5, 1, "R6 auto zero");

    // R8 invalid samples
    drive(3333, 6, 0, "R8");
    drive(3333, 7, 0, "R8");
    check("R10 ped_est", int'(ped_est), 0);

    // R7 measurement
    start = 1;
    drive(0, 0, 0, "R7");
    start = 0;
    check("R7 busy rise", int'(busy), 1);
    for (int c = 120; c < 128; c++) drive(4000, c, 1, "R7 pre-frame");
    sum = 0;
    for (int i = 0; i < 128; i++) begin
      if (i == 64) drive(4095, 63, 0, "R8 gap");
      if (i == 50) start = 1;
      drive(300 + (i % 8), i, 1, "R7 frame");
      start = 0;
      sum += 300 + (i % 8);
      if (i == 126) check("R7 busy during", int'(busy), 1);
    end
    tb_auto = sum >> 7;
    check("R7 busy end", int'(busy), 0);
    check("R7 R9 ped_est", int'(ped_est), 303);

    // R6 subtraction with measured estimate
    drive(303, 0, 1, "R6 auto");
    drive(310, 1, 1, "R6 auto");
    drive(10, 2, 1, "R4 auto clamp");

    // R10 estimate held without start, any mode
    for (int i = 0; i < 128; i++) drive(1000 + i, i, 1, "R10 frame");
    check("R10 held", int'(ped_est), 303);
    mode_manual = 1; manual_ped = 1000;
    drive(1500, 0, 1, "R5 manual");
    check("R10 manual mode", int'(ped_est), 303);
    mode_manual = 0;

    // second measurement
    start = 1;
    drive(0, 0, 0, "R7");
    start = 0;
    sum = 0;
    for (int i = 0; i < 128; i++) begin
      drive(2000 + (i % 2), i, 1, "R7 frame2");
      sum += 2000 + (i % 2);
    end
    tb_auto = sum >> 7;
    check("R7 ped_est 2", int'(ped_est), 2000);
    drive(2100, 0, 1, "R6 auto 2");
    sub_en = 0;
    drive(2100, 1, 1, "R3 bypass auto");
    repeat (4) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule